// File: doc/BRIEF.md
# Multi-Rail Soft-Start Sequencer

This block sequences the power-up of four regulated rails: a core rail driven by a switching stage, a bus-termination rail, a graphics-bus rail and a chipset rail. Two soft-start ramps are modelled as saturating counters. Their codes act as reference clamps for the analog loops. The primary ramp starts once the bias, 5 V and 3.3 V input supplies all report good. It jumps quickly to a code equal to about 1 V and then climbs steadily to full scale, which stands for 4.5 V. The termination rail follows this ramp. When the termination rail reports its 90 % level, the secondary ramp is released from zero. The secondary ramp clamps the core and graphics references together, and switching pulses are allowed once it passes the triangle-valley code.

The chipset rail does not wait for the supplies. It is enabled as soon as reset is released, so that it tracks the 3.3 V input while that input rises. A termination-good flag is latched on the first switching pulse once pulses are allowed, provided the termination rail is still above its hold threshold. Power-good reports that all four rails sit inside their windows. Fault counting lives in a separate supervisor. That supervisor drives `inhibit`, which collapses the secondary ramp and shuts the switched rails, and `restart`, which restarts the primary ramp.

Top module: `pwr_seq_top`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, all outputs are zero on the following edge: both ramps, all enables, `ramp_a_up`, `pwm_allow`, `term_good` and `pwr_good`.
- R2: Enable bit 3 (chipset rail) goes high on the first edge after reset is released and stays high whatever the supply flags are.
- R3: `ramp_a` stays 0 until `sup_bias`, `sup_5v` and `sup_3v3` are all high. On the first edge where all three are high it becomes JUMP_CODE (50) in one step.
- R4: After the jump, `ramp_a` rises by exactly 1 every STEP_CYC (2) clocks and saturates at FULL_CODE (225). If any supply flag drops, it clears to 0 on the next edge.
- R5: `ramp_a_up` equals (`ramp_a` > UP_CODE (200)) as sampled one clock earlier.
- R6: Enable bit 1 (termination rail) is high one clock after `ramp_a` is non-zero, with supplies good and no inhibit.
- R7: `ramp_b` stays 0 until `rail_good` bit 1 is high while `ramp_a` is running. It then climbs from 0 at the same rate to FULL_CODE, and enable bits 0 and 2 (core and graphics) go high.
- R8: `pwm_allow` equals (`ramp_b` ≥ VALLEY_CODE (62)) as sampled one clock earlier, and is low during inhibit.
- R9: `term_good` sets on an edge where `pwm_pulse` is high, `pwm_allow` is high and `term_hold` is high. A pulse that arrives with `pwm_allow` low or `term_hold` low leaves it clear. Once set, it stays set.
- R10: `pwr_good` is high exactly when all four `rail_good` bits were high one clock earlier, with supplies good and no inhibit.
- R11: One edge after `inhibit` is sampled high, `ramp_b`, `pwm_allow`, `term_good`, `pwr_good` and enable bits 0–2 are all 0. Enable bit 3 and `ramp_a` keep their values.
- R12: A one-clock `restart` clears `ramp_a` to 0 and clears `term_good`. With supplies still good, `ramp_a` jumps back to JUMP_CODE on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_bias | input | 1 | Bias supply above its threshold |
| sup_5v | input | 1 | 5 V input above its threshold |
| sup_3v3 | input | 1 | 3.3 V input above its threshold |
| rail_good | input | 4 | Per-rail window flags: bit0 core, bit1 termination (90 % level), bit2 graphics, bit3 chipset |
| term_hold | input | 1 | Termination rail above its hold threshold |
| pwm_pulse | input | 1 | A switching pulse occurred this cycle |
| inhibit | input | 1 | Supervisor shutdown of rails 0–2 |
| restart | input | 1 | Supervisor request to restart the primary ramp |
| rail_en | output | 4 | Per-rail enables, same bit order as `rail_good` |
| ramp_a | output | RAMP_W | Primary soft-start code |
| ramp_b | output | RAMP_W | Secondary soft-start code |
| ramp_a_up | output | 1 | Primary ramp above UP_CODE |
| pwm_allow | output | 1 | Secondary ramp at or above the valley code |
| term_good | output | 1 | Termination-good flag |
| pwr_good | output | 1 | All rails good |

## Verification
The bench targets the ramp edges. It checks the one-step jump from zero and the first increment exactly STEP_CYC clocks later. It also checks that the code holds at full scale. A design with an off-by-one divider, or one that skips the jump, shows the wrong code on those exact cycles. It checks the 200/201 and 61/62 threshold crossings, where a comparator of the wrong polarity or bound flips one clock early or late. It sends switching pulses before pulses are allowed and while the hold flag is low, which would wrongly latch `term_good` in a design that misses one of the gates. Inhibit, restart, loss of one supply and all-but-one `rail_good` patterns are applied one at a time. This shows that each clears only the state it owns and that the chipset rail survives all of them.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  // rail bit positions shared by enables and good flags
  localparam int RAIL_CORE = 0;
  localparam int RAIL_TERM = 1;
  localparam int RAIL_GFX  = 2;
  localparam int RAIL_CHIP = 3;
  localparam int NUM_RAILS = 4;
endpackage

// File: rtl/ss_ramp.sv
module ss_ramp #(
  parameter int W        = 8,
  parameter int JUMP     = 50,
  parameter int FULL     = 225,
  parameter int STEP_CYC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         clr,
  output logic [W-1:0] val
);
  localparam logic [W-1:0] FULL_C  = W'(FULL);
  localparam logic [W-1:0] JUMP_C  = W'(JUMP);
  localparam logic [W-1:0] FIRST_C = (JUMP > 0) ? W'(JUMP) : W'(1);

  logic hold0;
  logic need_jump;
  logic counting;
  logic step_now;

  assign hold0    = rst || clr || !run;
  assign counting = !need_jump && (val != FULL_C);

  generate
    if (JUMP > 0) begin : g_jump
      assign need_jump = (val < JUMP_C);
    end else begin : g_nojump
      assign need_jump = 1'b0;
    end

    if (STEP_CYC > 1) begin : g_div
      localparam int DW = $clog2(STEP_CYC);
      localparam logic [DW-1:0] DIV_LAST = DW'(STEP_CYC - 1);
      logic [DW-1:0] div;
      always_ff @(posedge clk) begin
        if (hold0)         div <= '0;
        else if (counting) div <= (div == DIV_LAST) ? '0 : div + 1'b1;
      end
      assign step_now = counting && (div == DIV_LAST);
    end else begin : g_nodiv
      assign step_now = counting;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (hold0)          val <= '0;
    else if (need_jump) val <= JUMP_C;
    else if (step_now)  val <= val + 1'b1;
  end

  // R4: never beyond full scale
  a_r4_ramp_ceiling: assert property (@(posedge clk) disable iff (rst)
    val <= FULL_C);
  // R4: once moving, a ramp advances by at most one code per clock
  a_r4_unit_step: assert property (@(posedge clk) disable iff (rst)
    ($past(val) != '0 && val != '0) |-> (val == $past(val) || val == $past(val) + 1'b1));
  // R3: leaving zero lands on the jump code (or 1 without a jump)
  a_r3_first_code: assert property (@(posedge clk) disable iff (rst)
    ($past(val) == '0 && val != '0) |-> (val == FIRST_C));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int W      = 8,
  parameter int UP     = 200,
  parameter int VALLEY = 62
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sup_ok,
  input  logic [W-1:0]         ramp_a,
  input  logic [W-1:0]         ramp_b,
  input  logic [NUM_RAILS-1:0] rail_good,
  input  logic                 term_hold,
  input  logic                 pwm_pulse,
  input  logic                 inhibit,
  input  logic                 restart,
  output logic                 b_go,
  output logic [NUM_RAILS-1:0] rail_en,
  output logic                 ramp_a_up,
  output logic                 pwm_allow,
  output logic                 term_good,
  output logic                 pwr_good
);
  localparam logic [W-1:0] UP_C     = W'(UP);
  localparam logic [W-1:0] VALLEY_C = W'(VALLEY);

  logic seq_kill;
  logic a_live;
  assign seq_kill = restart || inhibit || !sup_ok;
  assign a_live   = (ramp_a != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      b_go      <= 1'b0;
      rail_en   <= '0;
      ramp_a_up <= 1'b0;
      pwm_allow <= 1'b0;
      term_good <= 1'b0;
      pwr_good  <= 1'b0;
    end else begin
      ramp_a_up <= (ramp_a > UP_C);
      pwm_allow <= (ramp_b >= VALLEY_C) && !inhibit;
      pwr_good  <= (&rail_good) && sup_ok && !inhibit;

      if (seq_kill)                              b_go <= 1'b0;
      else if (a_live && rail_good[RAIL_TERM])   b_go <= 1'b1;

      if (seq_kill)                                      term_good <= 1'b0;
      else if (pwm_pulse && pwm_allow && term_hold)      term_good <= 1'b1;

      rail_en[RAIL_CHIP] <= 1'b1;
      rail_en[RAIL_TERM] <= a_live && sup_ok && !inhibit;
      rail_en[RAIL_CORE] <= b_go && !inhibit;
      rail_en[RAIL_GFX]  <= b_go && !inhibit;
    end
  end

  // R11: inhibit collapses the secondary ramp and the good flags in one clock
  a_r11_inhibit_clears: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> (ramp_b == '0 && !term_good && !pwr_good && !pwm_allow));
  // R10: a missing rail blocks power-good on the next clock
  a_r10_pg_needs_all: assert property (@(posedge clk) disable iff (rst)
    !(&rail_good) |=> !pwr_good);
  // R9: termination-good only rises on a qualified pulse
  a_r9_term_needs_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(term_good) |-> $past(pwm_pulse && term_hold && pwm_allow));
  // R2: chipset rail stays on once out of reset
  a_r2_chip_rail_on: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rail_en[RAIL_CHIP]);
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int RAMP_W      = 8,
  parameter int JUMP_CODE   = 50,
  parameter int FULL_CODE   = 225,
  parameter int UP_CODE     = 200,
  parameter int VALLEY_CODE = 62,
  parameter int STEP_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sup_bias,
  input  logic              sup_5v,
  input  logic              sup_3v3,
  input  logic [3:0]        rail_good,
  input  logic              term_hold,
  input  logic              pwm_pulse,
  input  logic              inhibit,
  input  logic              restart,
  output logic [3:0]        rail_en,
  output logic [RAMP_W-1:0] ramp_a,
  output logic [RAMP_W-1:0] ramp_b,
  output logic              ramp_a_up,
  output logic              pwm_allow,
  output logic              term_good,
  output logic              pwr_good
);
  logic sup_ok;
  logic b_go;
  assign sup_ok = sup_bias && sup_5v && sup_3v3;

  ss_ramp #(.W(RAMP_W), .JUMP(JUMP_CODE), .FULL(FULL_CODE), .STEP_CYC(STEP_CYC)) u_ramp_a (
    .clk(clk), .rst(rst), .run(sup_ok), .clr(restart), .val(ramp_a)
  );

  ss_ramp #(.W(RAMP_W), .JUMP(0), .FULL(FULL_CODE), .STEP_CYC(STEP_CYC)) u_ramp_b (
    .clk(clk), .rst(rst), .run(b_go), .clr(inhibit), .val(ramp_b)
  );

  seq_ctrl #(.W(RAMP_W), .UP(UP_CODE), .VALLEY(VALLEY_CODE)) u_ctrl (
    .clk(clk), .rst(rst), .sup_ok(sup_ok), .ramp_a(ramp_a), .ramp_b(ramp_b),
    .rail_good(rail_good), .term_hold(term_hold), .pwm_pulse(pwm_pulse),
    .inhibit(inhibit), .restart(restart), .b_go(b_go), .rail_en(rail_en),
    .ramp_a_up(ramp_a_up), .pwm_allow(pwm_allow), .term_good(term_good),
    .pwr_good(pwr_good)
  );
endmodule

// File: tb/sim_pwr_seq_top.sv
module sim_pwr_seq_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sup_bias = 0, sup_5v = 0, sup_3v3 = 0;
  logic [3:0] rail_good = 4'b0000;
  logic term_hold = 0, pwm_pulse = 0, inhibit = 0, restart = 0;
  logic [3:0] rail_en;
  logic [7:0] ramp_a, ramp_b;
  logic ramp_a_up, pwm_allow, term_good, pwr_good;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  pwr_seq_top u0 (
    .clk(clk), .rst(rst), .sup_bias(sup_bias), .sup_5v(sup_5v), .sup_3v3(sup_3v3),
    .rail_good(rail_good), .term_hold(term_hold), .pwm_pulse(pwm_pulse),
    .inhibit(inhibit), .restart(restart), .rail_en(rail_en), .ramp_a(ramp_a),
    .ramp_b(ramp_b), .ramp_a_up(ramp_a_up), .pwm_allow(pwm_allow),
    .term_good(term_good), .pwr_good(pwr_good)
  );

  // power-good table: {rail_good[3:0], expected pwr_good}  (R10)
  localparam logic [4:0] PG_VEC [7] = '{
    5'b1111_1, 5'b0111_0, 5'b1011_0, 5'b1101_0, 5'b1110_0, 5'b0000_0, 5'b1111_1
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish act=%0d exp=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  initial begin
    int prev;
    // R1: reset state
    tick(); tick();
    chk(ramp_a == 0 && ramp_b == 0 && rail_en == 0 && !ramp_a_up && !pwm_allow
        && !term_good && !pwr_good, "R1 reset outputs", {ramp_a, rail_en}, 0);

    // R2: chipset rail ahead of supplies
    rst = 0; tick();
    chk(rail_en == 4'b1000, "R2 chipset enable", rail_en, 4'b1000);
    sup_bias = 1; sup_5v = 1; tick(); tick();
    chk(ramp_a == 0, "R3 ramp waits for all supplies", ramp_a, 0);
    sup_3v3 = 1; tick();
    chk(ramp_a == 50, "R3 jump code", ramp_a, 50);
    tick();
    chk(ramp_a == 50, "R4 hold before first step", ramp_a, 50);
    chk(rail_en == 4'b1010, "R6 termination enable", rail_en, 4'b1010);
    tick();
    chk(ramp_a == 51, "R4 first step after STEP_CYC", ramp_a, 51);

    // R5 threshold tracked through the climb; R7 ramp_b idle
    prev = ramp_a;
    for (int i = 0; i < 400 && ramp_a != 225; i++) begin
      tick();
      if ((prev == 200) || (prev == 201))
        chk(ramp_a_up == (prev > 200), "R5 up flag at threshold", ramp_a_up, prev > 200);
      prev = ramp_a;
    end
    chk(ramp_a == 225, "R4 reaches full", ramp_a, 225);
    chk(ramp_b == 0, "R7 ramp_b idle before rail 2 good", ramp_b, 0);
    for (int i = 0; i < 6; i++) tick();
    chk(ramp_a == 225 && ramp_a_up, "R4 saturates at full", ramp_a, 225);

    // R7 release of secondary ramp
    rail_good = 4'b0010;
    for (int i = 0; i < 10 && ramp_b == 0; i++) tick();
    chk(ramp_b == 1, "R7 ramp_b starts from zero", ramp_b, 1);
    chk(rail_en == 4'b1111, "R7 core/gfx enables", rail_en, 4'b1111);

    // R9 early pulse ignored
    pwm_pulse = 1; term_hold = 1; tick(); pwm_pulse = 0; tick();
    chk(!term_good, "R9 pulse before pwm_allow ignored", term_good, 0);

    // R8 valley crossing
    prev = ramp_b;
    for (int i = 0; i < 400 && ramp_b < 64; i++) begin
      tick();
      if (prev == 61 || prev == 62)
        chk(pwm_allow == (prev >= 62), "R8 valley threshold", pwm_allow, prev >= 62);
      prev = ramp_b;
    end

    // R9 hold gate, then qualified pulse
    term_hold = 0; pwm_pulse = 1; tick(); pwm_pulse = 0; tick();
    chk(!term_good, "R9 pulse with hold low ignored", term_good, 0);
    term_hold = 1; pwm_pulse = 1; tick(); pwm_pulse = 0; tick(); tick();
    chk(term_good, "R9 term_good latched", term_good, 1);

    for (int i = 0; i < 400 && ramp_b != 225; i++) tick();
    chk(ramp_b == 225, "R7 ramp_b reaches full", ramp_b, 225);

    // R10 vector table
    foreach (PG_VEC[k]) begin
      rail_good = PG_VEC[k][4:1];
      tick();
      chk(pwr_good == PG_VEC[k][0], "R10 power-good pattern", pwr_good, PG_VEC[k][0]);
    end

    // R11 inhibit
    inhibit = 1; tick();
    chk(ramp_b == 0 && !pwm_allow && !term_good && !pwr_good, "R11 inhibit clears",
        {ramp_b, pwm_allow, term_good, pwr_good}, 0);
    tick();
    chk(rail_en == 4'b1000, "R11 rails 0-2 off", rail_en, 4'b1000);
    chk(ramp_a == 225, "R11 ramp_a kept", ramp_a, 225);
    inhibit = 0; tick(); tick();
    chk(!term_good, "R11 term_good stays clear", term_good, 0);

    // R12 restart
    restart = 1; tick(); restart = 0;
    chk(ramp_a == 0, "R12 restart clears ramp_a", ramp_a, 0);
    tick();
    chk(ramp_a == 50, "R12 re-jump", ramp_a, 50);

    // R4 supply loss
    sup_5v = 0; tick();
    chk(ramp_a == 0, "R4 supply loss clears ramp", ramp_a, 0);
    tick();
    chk(rail_en[3] == 1'b1, "R2 chipset survives supply loss", rail_en[3], 1);

    // R1 reset mid-run
    rst = 1; tick();
    chk(rail_en == 0 && ramp_a == 0 && ramp_b == 0, "R1 reset mid-run", rail_en, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule